// File: doc/BRIEF.md
# Interrupt Response Bus Sequencer

This block produces the T-state-by-T-state bus activity that an 8-bit processor core carries out when it takes an interrupt at an instruction boundary. It handles two responses. The first is the non-maskable interrupt, which is edge-triggered and held in a latch. The second is the maskable interrupt in restart-to-fixed-address mode, which is level-sensitive and gated by the interrupt-enable flag. One clock cycle is one T-state.

A response starts when the core raises `at_boundary` while a request is pending. The sequencer captures the program counter, the stack pointer and the enable flag. It then drives address, data, strobes and the wait-sampling marker. It writes the return address to the stack high byte first. At the end it pulses `done` and presents the new program counter, the new stack pointer, the new flag values and the measured length in T-states.

The non-maskable path runs a 5-T-state discarded opcode-style read with refresh, followed by two 3-T-state stack writes. The maskable path runs a 7-T-state acknowledge cycle, which wait requests can stretch, followed by the same two writes.

Top module: `irq_bus_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rd`, `wr`, `m1`, `iorq`, `rfsh` and `wsmp` are all 0, and `pc_out`, `sp_out`, `iff1_out` and `iff2_out` are 0.
- R2: An accepted non-maskable response lasts exactly 11 T-states (`busy` high for 11 cycles). It ends with a one-cycle `done` pulse, with `cyc_total` = 11, `is_nmi` = 1 and `pc_out` = 0x0066.
- R3: An accepted maskable response with no wait requests lasts exactly 13 T-states and ends with `cyc_total` = 13, `is_nmi` = 0 and `pc_out` = 0x0038.
- R4: Each response performs exactly two writes (`wr` high for one cycle each). The first writes PC[15:8] to SP-1. The second writes PC[7:0] to SP-2, with 16-bit wrap-around. At `done`, `sp_out` = SP-2.
- R5: At `done` after a non-maskable response, `iff2_out` equals the captured enable flag and `iff1_out` = 0. After a maskable response both are 0.
- R6: When a non-maskable request and an enabled maskable request are both pending at the same boundary, the non-maskable response is taken.
- R7: A maskable request with `iff1_in` = 0 at the boundary starts no response: `busy` stays 0 and no write occurs.
- R8: A rising edge of `nmi_req` is latched even when `at_boundary` is low, and it is served at the next boundary. A request held high starts only one response.
- R9: In the maskable path, each cycle in which `wait_n` is low while `wsmp` is high adds one T-state to the acknowledge phase, so the length becomes 13 plus the number of waits. The non-maskable path ignores `wait_n`.
- R10: Strobes by phase. In the non-maskable path, `rd` and `m1` are high for the first 2 T-states. In the maskable path, `m1` is high for the acknowledge phase and `iorq` is high for its last 2 T-states or more. In both paths, `rfsh` is high for the 2 T-states that follow, and `wr` never coincides with `rd`, `iorq` or `rfsh`.
- R11: Requests are not accepted while `at_boundary` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Core is at an instruction boundary |
| nmi_req | input | 1 | Non-maskable request, edge-detected |
| int_req | input | 1 | Maskable request, level-sampled |
| wait_n | input | 1 | Active-low wait request |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| iff1_in | input | 1 | Current interrupt-enable flag |
| busy | output | 1 | Response sequence in progress |
| is_nmi | output | 1 | Current/last response is non-maskable |
| addr | output | 16 | Bus address |
| dout | output | 8 | Write data |
| rd | output | 1 | Memory read strobe |
| wr | output | 1 | Memory write strobe |
| m1 | output | 1 | First machine cycle marker |
| iorq | output | 1 | Interrupt acknowledge strobe |
| rfsh | output | 1 | Refresh strobe |
| wsmp | output | 1 | T-state in which `wait_n` is sampled |
| done | output | 1 | One-cycle end-of-response pulse |
| cyc_total | output | CW | T-states taken by the last response |
| pc_out | output | 16 | New program counter (vector) |
| sp_out | output | 16 | New stack pointer |
| iff1_out | output | 1 | New enable flag |
| iff2_out | output | 1 | New saved enable flag |

## Verification
The bench uses the default parameters: vectors 0x0066 and 0x0038, an 8-bit length counter and a 7-bit refresh counter. With an 8-bit counter, maskable responses stretched by zero to three waits are measured without wrap. The 16-bit stack pointer lets a start value of 0x0001 exercise the push wrapping through 0x0000 to 0xFFFF. The random mix of both response types, random addresses and random flag states covers the flag-copy rule in both directions.

// File: rtl/irq_bus_seq.sv
module irq_bus_seq #(
  parameter logic [15:0] NMI_VEC = 16'h0066,
  parameter logic [15:0] IM1_VEC = 16'h0038,
  parameter int CW = 8,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_boundary,
  input  logic          nmi_req,
  input  logic          int_req,
  input  logic          wait_n,
  input  logic [15:0]   pc_in,
  input  logic [15:0]   sp_in,
  input  logic          iff1_in,
  output logic          busy,
  output logic          is_nmi,
  output logic [15:0]   addr,
  output logic [7:0]    dout,
  output logic          rd,
  output logic          wr,
  output logic          m1,
  output logic          iorq,
  output logic          rfsh,
  output logic          wsmp,
  output logic          done,
  output logic [CW-1:0] cyc_total,
  output logic [15:0]   pc_out,
  output logic [15:0]   sp_out,
  output logic          iff1_out,
  output logic          iff2_out
);
  typedef enum logic [3:0] {
    S_IDLE, S_F1, S_F2, S_A1, S_A2, S_AW1, S_AW2, S_R1,
    S_R2, S_X, S_H1, S_H2, S_H3, S_L1, S_L2, S_L3
  } st_t;

  st_t st, nxt;
  logic nmi_prev, nmi_pend, iff1_c;
  logic [15:0] pc_c, sp_c;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;

  wire idle     = (st == S_IDLE);
  wire nmi_hit  = nmi_pend | (nmi_req & ~nmi_prev);
  wire take_nmi = idle & at_boundary & nmi_hit;
  wire take_int = idle & at_boundary & ~nmi_hit & int_req & iff1_in;

  always_comb begin
    case (st)
      S_IDLE:  nxt = take_nmi ? S_F1 : (take_int ? S_A1 : S_IDLE);
      S_F1:    nxt = S_F2;
      S_F2:    nxt = S_R1;
      S_A1:    nxt = S_A2;
      S_A2:    nxt = S_AW1;
      S_AW1:   nxt = S_AW2;
      S_AW2:   nxt = wait_n ? S_R1 : S_AW2;
      S_R1:    nxt = S_R2;
      S_R2:    nxt = S_X;
      S_X:     nxt = S_H1;
      S_H1:    nxt = S_H2;
      S_H2:    nxt = S_H3;
      S_H3:    nxt = S_L1;
      S_L1:    nxt = S_L2;
      S_L2:    nxt = S_L3;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; nmi_prev <= 1'b0; nmi_pend <= 1'b0; iff1_c <= 1'b0;
      pc_c <= '0; sp_c <= '0; cnt <= '0; rcnt <= '0; is_nmi <= 1'b0;
      done <= 1'b0; cyc_total <= '0; pc_out <= '0; sp_out <= '0;
      iff1_out <= 1'b0; iff2_out <= 1'b0;
    end else begin
      st <= nxt;
      nmi_prev <= nmi_req;
      nmi_pend <= nmi_hit & ~take_nmi;
      done <= 1'b0;
      if (take_nmi | take_int) begin
        pc_c <= pc_in; sp_c <= sp_in; iff1_c <= iff1_in;
        is_nmi <= take_nmi; cnt <= CW'(1);
      end else if (!idle) begin
        cnt <= cnt + CW'(1);
      end
      if (st == S_R2) rcnt <= rcnt + RW'(1);
      if (st == S_L3) begin
        done <= 1'b1;
        cyc_total <= cnt;
        pc_out <= is_nmi ? NMI_VEC : IM1_VEC;
        sp_out <= sp_c - 16'd2;
        iff1_out <= 1'b0;
        iff2_out <= is_nmi & iff1_c;
      end
    end
  end

  wire in_push_hi = (st == S_H1) | (st == S_H2) | (st == S_H3);
  wire in_push_lo = (st == S_L1) | (st == S_L2) | (st == S_L3);

  assign busy = ~idle;
  assign rd   = (st == S_F1) | (st == S_F2);
  assign iorq = (st == S_AW1) | (st == S_AW2);
  assign m1   = rd | iorq | (st == S_A1) | (st == S_A2);
  assign rfsh = (st == S_R1) | (st == S_R2);
  assign wr   = (st == S_H2) | (st == S_L2);
  assign wsmp = (st == S_AW2);
  assign dout = in_push_hi ? pc_c[15:8] : (in_push_lo ? pc_c[7:0] : 8'h00);

  always_comb begin
    if (in_push_hi)      addr = sp_c - 16'd1;
    else if (in_push_lo) addr = sp_c - 16'd2;
    else if (rfsh)       addr = {{(16-RW){1'b0}}, rcnt};
    else if (idle)       addr = 16'h0000;
    else                 addr = pc_c;
  end
endmodule

// File: rtl/irq_bus_seq_chk.sv
module irq_bus_seq_chk #(parameter int CW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          wait_n,
  input logic          iff1_in,
  input logic          busy,
  input logic          is_nmi,
  input logic          rd,
  input logic          wr,
  input logic          m1,
  input logic          iorq,
  input logic          rfsh,
  input logic          wsmp,
  input logic          done,
  input logic [CW-1:0] cyc_total,
  input logic          iff1_out
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rd || wr || m1 || iorq || rfsh || wsmp));
  p_nmi_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_nmi) |-> int'(cyc_total) == 11);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_im1_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_nmi) |-> int'(cyc_total) >= 13);
  p_write_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !(rd || iorq || rfsh || m1));
  p_iff_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !iff1_out);
  p_int_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !is_nmi) |-> $past(iff1_in));
  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wsmp && !wait_n) |=> wsmp);
  p_ack_m1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    iorq |-> (m1 && !rd && !is_nmi));
endmodule

bind irq_bus_seq irq_bus_seq_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_irq_bus_seq.sv
module tb_irq_bus_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic at_boundary = 0, nmi_req = 0, int_req = 0, wait_n = 1, iff1_in = 0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic busy, is_nmi, rd, wr, m1, iorq, rfsh, wsmp, done, iff1_out, iff2_out;
  logic [15:0] addr, pc_out, sp_out;
  logic [7:0] dout;
  logic [7:0] cyc_total;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_bus_seq dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input bit nmi, input int waits);
    return nmi ? 11 : 13 + waits;
  endfunction

  task automatic no_resp(input string req);
    int b = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (busy || wr) b++;
    end
    chk(b == 0, req, b, 0);
  endtask

  task automatic run(input bit nmi, input bit intr, input bit i1, input logic [15:0] pc,
                     input logic [15:0] sp, input int waits, input bit exp_nmi, input bit keep_nmi);
    int len = 0, nw = 0, wl = waits, rdn = 0, rfn = 0;
    logic [15:0] wa[2];
    logic [7:0] wd[2];
    @(negedge clk);
    pc_in = pc; sp_in = sp; iff1_in = i1; int_req = intr; at_boundary = 1;
    if (nmi) nmi_req = 1;
    @(negedge clk);
    at_boundary = 0;
    if (exp_nmi && waits > 0) wait_n = 0;
    for (int k = 0; k < 60 && !done; k++) begin
      if (busy) len++;
      if (rd) rdn++;
      if (rfsh) rfn++;
      if (wr) begin
        if (nw < 2) begin wa[nw] = addr; wd[nw] = dout; end
        nw++;
      end
      if (!exp_nmi) begin
        if (wsmp && wl > 0) begin wait_n = 0; wl--; end
        else wait_n = 1;
      end
      @(negedge clk);
    end
    wait_n = 1; int_req = 0;
    if (!keep_nmi) nmi_req = 0;
    chk(done == 1, exp_nmi ? "R2" : "R3", done, 1);
    chk(len == exp_len(exp_nmi, waits), exp_nmi ? "R2 busy length" : "R9 busy length", len, exp_len(exp_nmi, waits));
    chk(int'(cyc_total) == exp_len(exp_nmi, waits), exp_nmi ? "R2 cyc_total" : "R9 cyc_total",
        cyc_total, exp_len(exp_nmi, waits));
    chk(is_nmi == exp_nmi, "R6 kind", is_nmi, exp_nmi);
    chk(pc_out == (exp_nmi ? 16'h0066 : 16'h0038), exp_nmi ? "R2 vector" : "R3 vector",
        pc_out, exp_nmi ? 16'h0066 : 16'h0038);
    chk(sp_out == sp - 16'd2, "R4 sp_out", sp_out, sp - 16'd2);
    chk(nw == 2, "R4 write count", nw, 2);
    if (nw >= 2) begin
      chk(wa[0] == sp - 16'd1 && wd[0] == pc[15:8], "R4 high byte", {wa[0], wd[0]}, {sp - 16'd1, pc[15:8]});
      chk(wa[1] == sp - 16'd2 && wd[1] == pc[7:0], "R4 low byte", {wa[1], wd[1]}, {sp - 16'd2, pc[7:0]});
    end
    chk(iff1_out == 0 && iff2_out == (exp_nmi ? i1 : 1'b0), "R5 flags", {iff1_out, iff2_out},
        {1'b0, exp_nmi ? i1 : 1'b0});
    chk(rdn == (exp_nmi ? 2 : 0) && rfn == 2, "R10 strobe counts", {rdn, rfn}, {exp_nmi ? 2 : 0, 2});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd && !wr && !m1 && !iorq && !rfsh && !wsmp, "R1 strobes", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pc_out == 0 && sp_out == 0 && !iff1_out && !iff2_out && !busy, "R1 outputs", pc_out, 0);

    run(1, 0, 1, 16'h1234, 16'hF000, 0, 1, 0);
    run(0, 1, 1, 16'hABCD, 16'h8000, 0, 0, 0);
    run(0, 1, 1, 16'h0102, 16'h4000, 3, 0, 0);
    run(1, 0, 0, 16'h5555, 16'h0001, 2, 1, 0);
    run(1, 1, 1, 16'h2222, 16'h3000, 0, 1, 0);

    int_req = 1; iff1_in = 0; at_boundary = 1;
    no_resp("R7 disabled int");
    at_boundary = 0; iff1_in = 1;
    no_resp("R11 no boundary");
    int_req = 0;

    run(1, 0, 1, 16'h7777, 16'h2000, 0, 1, 1);
    at_boundary = 1;
    no_resp("R8 held nmi");
    at_boundary = 0; nmi_req = 0;
    @(negedge clk); nmi_req = 1;
    @(negedge clk); @(negedge clk); nmi_req = 0;
    run(0, 0, 1, 16'h4321, 16'h1000, 0, 1, 0);

    for (int i = 0; i < 40; i++) begin
      bit k = 1'($urandom % 2);
      run(k, !k, k ? 1'($urandom % 2) : 1'b1, 16'($urandom), 16'($urandom), int'($urandom % 4), k, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule